// File: doc/BRIEF.md
# Memory Self-Test Controller

This block runs a built-in self-test over a memory with a 64-bit data path. Software configures it through a small word-indexed register port and starts a run by writing the control word with the run bit set. During a pass the controller asks an external address sequencer for each address in turn, and writes a generated 64-bit pattern to every address. It then asks the sequencer for the same addresses again, reads each one back, and compares the returned data with the pattern.

Either of two patterns can be written. The walking pattern uses the address itself as data. The interleave pattern repeats a pair of programmable 32-bit words. The comparison can ignore selected pairs of byte lanes. The first mismatch is kept, with its address and its 64-bit read data. A run can be one pass or a loop of passes, and it can either stop at the first mismatch or carry on to the end. Writing the control word with the run bit clear aborts a run at the next transaction boundary.

The controller has at most one memory transaction or one sequencer request open at any time. Every request is held until it is answered.

Top module: `mem_selftest_ctrl`

## Requirements
- R1: Registers are selected by a 3-bit word index: 0 control, 1 status, 2 fail address, 3 fail data bits 31:0, 4 fail data bits 63:32, 5 odd word, 6 even word, 7 lane mask. After reset the control, status and mask words read 0, the odd word reads 0x55555555 and the even word reads 0xAAAAAAAA.
- R2: The control word has loop at bit 0, run at bit 1, mode at bit 2 and continue-on-error at bit 3. The status word has done at bit 0 and a 2-bit error code at bits 2:1. Writing control with bit 1 set starts a pass that first writes every address the sequencer supplies and then reads every address back. The first sequencer request of each phase carries `seq_first`.
- R3: In mode 0 the write data is the 32-bit address zero-extended to 64 bits. In mode 1 the write data is {even word, odd word}.
- R4: Mask bit k set removes byte lanes k and k+4 (bits 8k+7:8k and 8k+39:8k+32) from the comparison. A mask of 0 compares all eight lanes.
- R5: With continue-on-error 0, a mismatch ends the run at that read. The error code becomes 01, the fail address and fail data take the mismatching read, done becomes 1 and the run bit reads 0. This holds in loop mode too.
- R6: With continue-on-error 1, every read of the pass is still made. Only the first mismatch since the start is kept in the fail address and fail data.
- R7: When a one-shot pass ends, done reads 1 and the run bit reads 0. The error code stays 00 if no unmasked mismatch was seen.
- R8: With loop written as 1 together with the run bit, passes repeat while the run bit stays set. Done stays 0 during this.
- R9: Writing control with bit 1 clear aborts the run at the next transaction boundary. Done stays 0, and the error code, fail address and fail data are left unchanged.
- R10: Writing control with bit 1 set clears the error code and done before the new run.
- R11: A memory request keeps its address and direction until its response arrives. A sequencer request and a memory request are never active together. Each address gets exactly one write per pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| seq_req | output | 1 | Request for the next test address |
| seq_first | output | 1 | Request is the first of a phase; sequencer restarts its range |
| seq_vld | input | 1 | Sequencer answer strobe |
| seq_addr | input | 32 | Address supplied with `seq_vld` |
| seq_last | input | 1 | Supplied address is the last of the range |
| mem_req | output | 1 | Memory transaction request, held until response |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Transaction address |
| mem_wdata | output | 64 | Pattern data; during reads it shows the expected value |
| mem_rsp_vld | input | 1 | Memory response strobe (write done or read data valid) |
| mem_rsp_data | input | 64 | Read data |

## Verification
A register write takes effect at the clock edge that samples it, and a start or an abort is seen on `reg_rdata` at the next falling edge. The bench therefore reads status one half-cycle after its write, which shows the clear from R10 before any pass has begun. Run completion depends on sequencer and memory latency, so the bench polls the run bit at falling edges instead of counting cycles, and compares the final status, capture and access counts only after that bit has dropped. The memory and sequencer models answer each request one edge later and never answer twice. Loop checks are made at a fixed point well past one full pass, about 70 cycles with eight addresses.

// File: rtl/mst_pkg.sv
package mst_pkg;

  localparam int unsigned MST_AW    = 32;
  localparam int unsigned MST_DW    = 64;
  localparam int unsigned MST_RW    = 32;
  localparam int unsigned MST_PAIRS = MST_DW / 16;
  localparam int unsigned MST_IDX_W = 3;

  // register word indices
  localparam logic [MST_IDX_W-1:0] IDX_CTRL  = 3'd0;
  localparam logic [MST_IDX_W-1:0] IDX_STAT  = 3'd1;
  localparam logic [MST_IDX_W-1:0] IDX_FADDR = 3'd2;
  localparam logic [MST_IDX_W-1:0] IDX_FLO   = 3'd3;
  localparam logic [MST_IDX_W-1:0] IDX_FHI   = 3'd4;
  localparam logic [MST_IDX_W-1:0] IDX_ODD   = 3'd5;
  localparam logic [MST_IDX_W-1:0] IDX_EVEN  = 3'd6;
  localparam logic [MST_IDX_W-1:0] IDX_MASK  = 3'd7;

  // control bit positions (software decodes these)
  localparam int unsigned CB_LOOP = 0;
  localparam int unsigned CB_RUN  = 1;
  localparam int unsigned CB_MODE = 2;
  localparam int unsigned CB_COE  = 3;

  localparam logic [1:0] ERR_NONE     = 2'b00;
  localparam logic [1:0] ERR_MISMATCH = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WADR,
    ST_WMEM,
    ST_RADR,
    ST_RMEM
  } mst_state_e;

  // data written to (and expected back from) one address
  function automatic logic [MST_DW-1:0] mst_pattern(
    input logic              mode,
    input logic [MST_AW-1:0] addr,
    input logic [MST_RW-1:0] even_w,
    input logic [MST_RW-1:0] odd_w
  );
    if (mode) return {even_w, odd_w};
    return {{(MST_DW-MST_AW){1'b0}}, addr};
  endfunction

endpackage

// File: rtl/mst_regs.sv
module mst_regs
  import mst_pkg::*;
#(
  parameter int unsigned AW    = MST_AW,
  parameter int unsigned DW    = MST_DW,
  parameter int unsigned RW    = MST_RW,
  parameter int unsigned PAIRS = MST_PAIRS,
  parameter logic [RW-1:0] ODD_RST  = 32'h5555_5555,
  parameter logic [RW-1:0] EVEN_RST = 32'hAAAA_AAAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [MST_IDX_W-1:0] idx,
  input  logic [RW-1:0]        wdata,
  output logic [RW-1:0]        rdata,
  output logic                 cfg_loop,
  output logic                 cfg_mode,
  output logic                 cfg_coe,
  output logic [PAIRS-1:0]     cfg_mask,
  output logic [RW-1:0]        cfg_odd,
  output logic [RW-1:0]        cfg_even,
  output logic                 start,
  output logic                 abort,
  input  logic                 run,
  input  logic                 done,
  input  logic [1:0]           err,
  input  logic [AW-1:0]        fail_addr,
  input  logic [DW-1:0]        fail_data
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (idx == IDX_CTRL);
  assign start   = ctrl_wr &&  wdata[CB_RUN];
  assign abort   = ctrl_wr && !wdata[CB_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_loop <= 1'b0;
      cfg_mode <= 1'b0;
      cfg_coe  <= 1'b0;
      cfg_mask <= '0;
      cfg_odd  <= ODD_RST;
      cfg_even <= EVEN_RST;
    end else if (wr_en) begin
      unique case (idx)
        IDX_CTRL: begin
          cfg_loop <= wdata[CB_LOOP];
          cfg_mode <= wdata[CB_MODE];
          cfg_coe  <= wdata[CB_COE];
        end
        IDX_ODD:  cfg_odd  <= wdata;
        IDX_EVEN: cfg_even <= wdata;
        IDX_MASK: cfg_mask <= wdata[PAIRS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_CTRL: begin
        rdata[CB_LOOP] = cfg_loop;
        rdata[CB_RUN]  = run;
        rdata[CB_MODE] = cfg_mode;
        rdata[CB_COE]  = cfg_coe;
      end
      IDX_STAT: begin
        rdata[0]   = done;
        rdata[2:1] = err;
      end
      IDX_FADDR: rdata = fail_addr[RW-1:0];
      IDX_FLO:   rdata = fail_data[RW-1:0];
      IDX_FHI:   rdata = fail_data[RW +: RW];
      IDX_ODD:   rdata = cfg_odd;
      IDX_EVEN:  rdata = cfg_even;
      IDX_MASK:  rdata[PAIRS-1:0] = cfg_mask;
      default:   rdata = '0;
    endcase
  end

  // R10: a start write always leaves the control readback showing a run
  assert_start_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run);

endmodule

// File: rtl/mst_cmp.sv
module mst_cmp
  import mst_pkg::*;
#(
  parameter int unsigned DW    = MST_DW,
  parameter int unsigned PAIRS = MST_PAIRS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    exp_data,
  input  logic [DW-1:0]    got_data,
  input  logic [PAIRS-1:0] mask,
  output logic             miss
);

  localparam int unsigned HALF = DW / 2;

  logic [PAIRS-1:0] pair_bad;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic lo_diff, hi_diff;
    assign lo_diff     = exp_data[8*k +: 8]      != got_data[8*k +: 8];
    assign hi_diff     = exp_data[HALF+8*k +: 8] != got_data[HALF+8*k +: 8];
    assign pair_bad[k] = !mask[k] && (lo_diff || hi_diff);
  end

  assign miss = |pair_bad;

  // R4: identical data never reports a mismatch, whatever the mask
  assert_equal_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_data == got_data) |-> !miss);

  // R4: a fully masked compare never reports a mismatch
  assert_full_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !miss);

endmodule

// File: rtl/mst_capture.sv
module mst_capture
  import mst_pkg::*;
#(
  parameter int unsigned AW = MST_AW,
  parameter int unsigned DW = MST_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          hit,
  input  logic [AW-1:0] hit_addr,
  input  logic [DW-1:0] hit_data,
  output logic [1:0]    err,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_data
);

  logic take;
  assign take = hit && (err == ERR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err       <= ERR_NONE;
      fail_addr <= '0;
      fail_data <= '0;
    end else if (clear) begin
      err <= ERR_NONE;
    end else if (take) begin
      err       <= ERR_MISMATCH;
      fail_addr <= hit_addr;
      fail_data <= hit_data;
    end
  end

  // R6: once an error is held, later mismatches do not overwrite it
  assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err != ERR_NONE && !clear) |=> ($stable(fail_addr) && $stable(fail_data)));

  // R10: a start clears the error code
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err == ERR_NONE));

endmodule

// File: rtl/mst_fsm.sv
module mst_fsm
  import mst_pkg::*;
#(
  parameter int unsigned AW = MST_AW,
  parameter int unsigned DW = MST_DW,
  parameter int unsigned RW = MST_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic          cfg_loop,
  input  logic          cfg_mode,
  input  logic          cfg_coe,
  input  logic [RW-1:0] cfg_even,
  input  logic [RW-1:0] cfg_odd,
  output logic          seq_req,
  output logic          seq_first,
  input  logic          seq_vld,
  input  logic [AW-1:0] seq_addr,
  input  logic          seq_last,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_vld,
  input  logic          miss,
  output logic          rd_check,
  output logic          run,
  output logic          done
);

  mst_state_e    state, state_d;
  logic          first_q, first_d;
  logic          last_q, last_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          run_q, run_d;
  logic          done_q, done_d;

  // named events used by the logic and the assertions
  logic stop_hit;
  logic pass_end;
  assign rd_check = (state == ST_RMEM) && mem_rsp_vld;
  assign stop_hit = rd_check && miss && !cfg_coe;
  assign pass_end = rd_check && last_q;

  assign seq_req   = ((state == ST_WADR) || (state == ST_RADR)) && run_q;
  assign seq_first = seq_req && first_q;
  assign mem_req   = (state == ST_WMEM) || (state == ST_RMEM);
  assign mem_we    = (state == ST_WMEM);
  assign mem_addr  = addr_q;
  assign mem_wdata = mst_pattern(cfg_mode, addr_q, cfg_even, cfg_odd);
  assign run       = run_q;
  assign done      = done_q;

  always_comb begin
    state_d = state;
    first_d = first_q;
    last_d  = last_q;
    addr_d  = addr_q;
    run_d   = run_q;
    done_d  = done_q;
    unique case (state)
      ST_IDLE: begin
        if (run_q) begin
          state_d = ST_WADR;
          first_d = 1'b1;
        end
      end
      ST_WADR, ST_RADR: begin
        if (!run_q) begin
          state_d = ST_IDLE;
        end else if (seq_vld) begin
          addr_d  = seq_addr;
          last_d  = seq_last;
          first_d = 1'b0;
          state_d = (state == ST_WADR) ? ST_WMEM : ST_RMEM;
        end
      end
      ST_WMEM: begin
        if (mem_rsp_vld) begin
          if (last_q) begin
            state_d = ST_RADR;
            first_d = 1'b1;
          end else begin
            state_d = ST_WADR;
          end
        end
      end
      ST_RMEM: begin
        if (mem_rsp_vld) begin
          if (stop_hit) begin
            state_d = ST_IDLE;
            done_d  = run_q;
            run_d   = 1'b0;
          end else if (pass_end) begin
            if (run_q && cfg_loop) begin
              state_d = ST_WADR;
              first_d = 1'b1;
            end else begin
              state_d = ST_IDLE;
              done_d  = run_q;
              run_d   = 1'b0;
            end
          end else begin
            state_d = ST_RADR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) run_d = 1'b0;
    if (start) begin
      run_d  = 1'b1;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      addr_q  <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state   <= state_d;
      first_q <= first_d;
      last_q  <= last_d;
      addr_q  <= addr_d;
      run_q   <= run_d;
      done_q  <= done_d;
    end
  end

  // R11: an open memory request keeps its address and direction
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_vld) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: never a sequencer request and a memory request together
  assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && seq_req));

  // R5: a mismatch under stop-on-error ends the run
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && !start) |=> (!run_q && state == ST_IDLE));

  // R3: walking writes carry a zero upper half
  assert_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !cfg_mode) |-> (mem_wdata[DW-1:AW] == '0));

  // R9: an abort write drops the run bit
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !run_q);

endmodule

// File: rtl/mem_selftest_ctrl.sv
module mem_selftest_ctrl
  import mst_pkg::*;
#(
  parameter int unsigned AW    = MST_AW,
  parameter int unsigned DW    = MST_DW,
  parameter int unsigned RW    = MST_RW,
  parameter int unsigned PAIRS = MST_PAIRS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [MST_IDX_W-1:0] reg_idx,
  input  logic [RW-1:0]        reg_wdata,
  output logic [RW-1:0]        reg_rdata,
  output logic                 seq_req,
  output logic                 seq_first,
  input  logic                 seq_vld,
  input  logic [AW-1:0]        seq_addr,
  input  logic                 seq_last,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  input  logic                 mem_rsp_vld,
  input  logic [DW-1:0]        mem_rsp_data
);

  logic             cfg_loop, cfg_mode, cfg_coe;
  logic [PAIRS-1:0] cfg_mask;
  logic [RW-1:0]    cfg_odd, cfg_even;
  logic             start, abort;
  logic             run, done;
  logic [1:0]       err;
  logic [AW-1:0]    fail_addr;
  logic [DW-1:0]    fail_data;
  logic             miss, rd_check, cap_hit;

  assign cap_hit = rd_check && miss;

  mst_regs #(.AW(AW), .DW(DW), .RW(RW), .PAIRS(PAIRS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg_loop(cfg_loop), .cfg_mode(cfg_mode), .cfg_coe(cfg_coe),
    .cfg_mask(cfg_mask), .cfg_odd(cfg_odd), .cfg_even(cfg_even),
    .start(start), .abort(abort),
    .run(run), .done(done), .err(err),
    .fail_addr(fail_addr), .fail_data(fail_data)
  );

  mst_fsm #(.AW(AW), .DW(DW), .RW(RW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(start), .abort(abort),
    .cfg_loop(cfg_loop), .cfg_mode(cfg_mode), .cfg_coe(cfg_coe),
    .cfg_even(cfg_even), .cfg_odd(cfg_odd),
    .seq_req(seq_req), .seq_first(seq_first), .seq_vld(seq_vld),
    .seq_addr(seq_addr), .seq_last(seq_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rsp_vld(mem_rsp_vld),
    .miss(miss), .rd_check(rd_check), .run(run), .done(done)
  );

  mst_cmp #(.DW(DW), .PAIRS(PAIRS)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .exp_data(mem_wdata), .got_data(mem_rsp_data),
    .mask(cfg_mask), .miss(miss)
  );

  mst_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .clear(start), .hit(cap_hit),
    .hit_addr(mem_addr), .hit_data(mem_rsp_data),
    .err(err), .fail_addr(fail_addr), .fail_data(fail_data)
  );

endmodule

// File: tb/test_mem_selftest_ctrl.sv
`timescale 1ns/1ps
module test_mem_selftest_ctrl;

  localparam logic [31:0] BASE  = 32'h0000_0100;
  localparam int          NADDR = 8;

  typedef struct packed {
    logic        mode;
    logic        coe;
    logic [3:0]  mask;
    logic [7:0]  fbits;
    logic [63:0] flip;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 4'h0, 8'h00, 64'h0},
    '{1'b0, 1'b0, 4'h0, 8'h08, 64'h0000_0000_0000_FF00},
    '{1'b1, 1'b1, 4'h0, 8'h24, 64'h0100_0000_0000_0000},
    '{1'b1, 1'b0, 4'h2, 8'hFF, 64'h0000_FF00_0000_0000},
    '{1'b0, 1'b0, 4'h1, 8'h40, 64'h00FF_0000_0000_0000},
    '{1'b1, 1'b0, 4'hF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        seq_req, seq_first;
  logic        seq_vld = 1'b0;
  logic [31:0] seq_addr = 32'h0;
  logic        seq_last = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_rsp_vld = 1'b0;
  logic [63:0] mem_rsp_data = 64'h0;

  always #2.5 clk = ~clk;

  mem_selftest_ctrl i_mem_selftest_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_req(seq_req), .seq_first(seq_first), .seq_vld(seq_vld),
    .seq_addr(seq_addr), .seq_last(seq_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_vld(mem_rsp_vld), .mem_rsp_data(mem_rsp_data)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] mem [NADDR];
  logic [7:0]  fault_bits = 8'h0;
  logic [63:0] flip = 64'h0;
  int          rd_count = 0;
  int          wr_count = 0;
  int          first_cnt = 0;
  int          sidx = 0;

  // memory and sequencer models: one answer, one edge after each request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_vld <= 1'b0;
      seq_vld     <= 1'b0;
    end else begin
      mem_rsp_vld <= mem_req && !mem_rsp_vld;
      if (mem_req && !mem_rsp_vld) begin
        if (mem_we) begin
          mem[mem_addr[5:3]] <= mem_wdata;
          wr_count <= wr_count + 1;
        end else begin
          mem_rsp_data <= mem[mem_addr[5:3]] ^ (fault_bits[mem_addr[5:3]] ? flip : 64'h0);
          rd_count <= rd_count + 1;
        end
      end
      seq_vld <= seq_req && !seq_vld;
      if (seq_req && !seq_vld) begin
        if (seq_first) begin
          seq_addr  <= BASE;
          seq_last  <= (NADDR == 1);
          sidx      <= 0;
          first_cnt <= first_cnt + 1;
        end else begin
          seq_addr <= BASE + 32'((sidx + 1) * 8);
          seq_last <= (sidx + 2 == NADDR);
          sidx     <= sidx + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, v);
      if (!v[1]) return;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic loop, input logic mode, input logic coe);
    return {28'h0, coe, mode, 1'b1, loop};
  endfunction

  function automatic logic [63:0] exp_word(input logic mode, input int i,
                                          input logic [31:0] ev, input logic [31:0] od);
    if (mode) return {ev, od};
    return {32'h0, BASE + 32'(i * 8)};
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    int r0, w0, f0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(3'd0, v); chk("R1", "control reset", 64'(v), 64'h0);
    rd(3'd1, v); chk("R1", "status reset", 64'(v), 64'h0);
    rd(3'd5, v); chk("R1", "odd reset", 64'(v), 64'h5555_5555);
    rd(3'd6, v); chk("R1", "even reset", 64'(v), 64'hAAAA_AAAA);
    rd(3'd7, v); chk("R1", "mask reset", 64'(v), 64'h0);

    // table of one-shot runs
    for (int n = 0; n < 6; n++) begin
      vec_t   t;
      logic [63:0] keep;
      int     first;
      int     exp_rd;
      t = VECS[n];
      keep = 64'h0;
      for (int k = 0; k < 4; k++)
        if (!t.mask[k]) keep |= (64'hFF << (8 * k)) | (64'hFF << (8 * k + 32));
      first = -1;
      for (int i = 0; i < NADDR; i++)
        if (first < 0 && t.fbits[i] && ((t.flip & keep) != 64'h0)) first = i;
      exp_rd = (first >= 0 && !t.coe) ? first + 1 : NADDR;

      fault_bits = t.fbits;
      flip = t.flip;
      wr(3'd7, {28'h0, t.mask});
      r0 = rd_count; w0 = wr_count; f0 = first_cnt;
      wr(3'd0, ctrl_word(1'b0, t.mode, t.coe));
      wait_idle();

      rd(3'd1, v);
      chk("R7", $sformatf("vec%0d done", n), 64'(v[0]), 64'h1);
      chk(first >= 0 ? (t.coe ? "R6" : "R5") : "R4", $sformatf("vec%0d error code", n),
          64'(v[2:1]), (first >= 0) ? 64'h1 : 64'h0);
      chk(t.coe ? "R6" : "R5", $sformatf("vec%0d reads", n), 64'(rd_count - r0), 64'(exp_rd));
      chk("R11", $sformatf("vec%0d writes", n), 64'(wr_count - w0), 64'(NADDR));
      chk("R2", $sformatf("vec%0d phase starts", n), 64'(first_cnt - f0), 64'h2);
      if (first >= 0) begin
        rd(3'd2, v);
        chk("R5", $sformatf("vec%0d fail address", n), 64'(v), 64'(BASE + 32'(first * 8)));
        rd(3'd3, lo);
        rd(3'd4, hi);
        chk("R6", $sformatf("vec%0d fail data", n), {hi, lo},
            exp_word(t.mode, first, 32'hAAAA_AAAA, 32'h5555_5555) ^ t.flip);
      end
      chk("R3", $sformatf("vec%0d written word", n), mem[7],
          exp_word(t.mode, 7, 32'hAAAA_AAAA, 32'h5555_5555));
    end

    // R3: programmed interleave words
    fault_bits = 8'h0;
    wr(3'd7, 32'h0);
    wr(3'd5, 32'h1234_5678);
    wr(3'd6, 32'h9ABC_DEF0);
    wr(3'd0, ctrl_word(1'b0, 1'b1, 1'b0));
    wait_idle();
    chk("R3", "interleave word", mem[5], 64'h9ABC_DEF0_1234_5678);
    rd(3'd1, v); chk("R7", "clean interleave status", 64'(v), 64'h1);

    // R8 / R9: clean loop, then abort
    r0 = rd_count;
    wr(3'd0, ctrl_word(1'b1, 1'b0, 1'b0));
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk("R8", "loop still running", 64'(v[1]), 64'h1);
    rd(3'd1, v); chk("R8", "loop done flag", 64'(v[0]), 64'h0);
    chk("R8", "loop read more than one pass", 64'(rd_count - r0 > NADDR), 64'h1);
    wr(3'd0, 32'h0);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk("R9", "abort status", 64'(v), 64'h0);
    chk("R9", "memory idle after abort", 64'(mem_req), 64'h0);

    // R6 / R8 / R9 / R10: loop with continue-on-error
    fault_bits = 8'h02;
    flip = 64'h1;
    r0 = rd_count;
    wr(3'd0, ctrl_word(1'b1, 1'b0, 1'b1));
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk("R8", "loop continues after error", 64'(v[1]), 64'h1);
    rd(3'd1, v); chk("R6", "loop error code", 64'(v[2:1]), 64'h1);
    chk("R6", "loop reads past first pass", 64'(rd_count - r0 > NADDR), 64'h1);
    wr(3'd0, 32'h0);
    wait_idle();
    rd(3'd1, v); chk("R9", "error kept after abort", 64'(v), 64'h2);
    rd(3'd2, v); chk("R9", "fail address kept", 64'(v), 64'(BASE + 32'h8));
    fault_bits = 8'h0;
    wr(3'd0, ctrl_word(1'b0, 1'b0, 1'b0));
    rd(3'd1, v); chk("R10", "status cleared by start", 64'(v), 64'h0);
    wait_idle();
    rd(3'd1, v); chk("R7", "done after clean run", 64'(v), 64'h1);

    // R5: loop with stop-on-error ends at the mismatch
    fault_bits = 8'h10;
    flip = 64'h1;
    wr(3'd0, ctrl_word(1'b1, 1'b0, 1'b0));
    wait_idle();
    rd(3'd1, v); chk("R5", "loop stop status", 64'(v), 64'h3);
    rd(3'd2, v); chk("R5", "loop stop address", 64'(v), 64'(BASE + 32'h20));

    summary();
    $finish;
  end

endmodule